// File: doc/BRIEF.md
# Pipelined Bit-Serial Exponential Unit

This block evaluates e^a for a fractional argument 0 ≤ a < 1. It uses a shift-and-add convergence scheme. A chain of identical stages runs the iterations, and each stage executes exactly one iteration index. Stage i forms a candidate pair: x grown by its own copy shifted right by i, and y reduced by the constant ln(1+2^-i). The stage keeps the candidate only when the reduced y is still strictly positive. Otherwise it forwards the incoming pair unchanged. After the last stage, x holds the approximation of e^a.

All arithmetic is bit-serial, least significant bit first, over fixed slots of W cycles. One free-running phase counter, started by reset, frames every slot. All stages therefore start and finish their words in the same cycles. A single constant store holds every ln(1+2^-i) once in rotating rings and drives one bit per stage per cycle. That broadcast is also visible on a port.

The argument enters serially, one bit per cycle, during one slot. The result leaves serially NSTAGE+1 slots later. A new word may enter in every slot.

Top module: `bsexp_pipe`

## Requirements
- R1: With default parameters, the result read as an unsigned number with W-2 fractional bits lies within 32 LSB of e^a, where the argument is read as an unsigned W-bit fraction.
- R2: A word whose first bit is presented in slot s is output in slot s+NSTAGE+1, least significant bit at phase 0. During that slot, res_valid is high on all W cycles.
- R3: The result equals, bit for bit, this integer procedure:
  - Start with x = 2^(W-2) and y = a.
  - For i = 0 to NSTAGE-1, set c = round(ln(1+2^-i)·2^W) and x' = (x + floor(x/2^i)) mod 2^W.
  - If y > c, replace x with x' and y with y - c. Otherwise leave both unchanged.
- R4: A candidate whose reduced y is exactly zero is discarded. With a = c_0 the result is below 2^(W-1). With a = c_0+1 the result is exactly 2^(W-1), i.e. 2.0.
- R5: An argument of 0 yields exactly 2^(W-2), i.e. 1.0.
- R6: In the cycle of phase k, kbits[i] equals bit k of c_i.
- R7: slot_first is high exactly in the cycles of phase 0. Phase 0 is the first cycle after reset is released, and the phase then advances by one per cycle modulo W.
- R8: op_valid is sampled only in the cycle of phase 0. Its value in any other cycle has no effect.
- R9: A slot without a valid word produces res_valid low and res_bit low in its output slot, and leaves neighbouring results unchanged.
- R10: While reset is held, slot_first is high and res_valid and res_bit are low.
- R11: A retained x update never carries out of W bits. For a = 2^W-1 the result stays above 2^(W-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all stages and the constant store |
| rst | input | 1 | Synchronous active-high reset; restarts the phase at 0 |
| op_valid | input | 1 | Marks the slot's argument as valid; sampled at phase 0 only |
| op_bit | input | 1 | Argument bit, least significant first, bit k at phase k |
| slot_first | output | 1 | High in the phase-0 cycle of every slot |
| res_valid | output | 1 | High for the whole slot carrying a result word |
| res_bit | output | 1 | Result bit, least significant first; low when no result |
| kbits | output | NSTAGE | Constant broadcast; bit i is the current bit of c_i |

## Verification
The hardest case to reach from the ports is a candidate residual of exactly zero at some stage, because it only occurs for arguments that line up with a sum of the stored constants. The bench derives c_0 from a real logarithm and feeds c_0, c_0+1 and c_0-1 directly, so the strict-positive test is hit at stage 0 with a known outcome. The bench also drives op_valid inverted on every cycle except phase 0, and mixes bubble slots carrying random bits between back-to-back valid words. A cycle-exact queue model compares every output bit against these inputs.

// File: rtl/bsexp_pkg.sv
package bsexp_pkg;

   localparam int FPREC = 48;

   // ln(1+2^-idx) rounded to frac_bits fractional bits, via 2*atanh(1/(2^(idx+1)+1))
   function automatic longint unsigned ln1p_pow2(input int idx, input int frac_bits);
      longint unsigned d;
      longint unsigned d2;
      longint unsigned p;
      longint unsigned s;
      longint unsigned dv;
      d  = (64'd1 << (idx + 1)) + 64'd1;
      d2 = d * d;
      p  = (64'd1 << FPREC) / d;
      s  = 64'd0;
      for (int k = 0; k < 24; k++) begin
         dv = 64'(2 * k + 1);
         s  = s + p / dv;
         p  = p / d2;
      end
      return ((s << 1) + (64'd1 << (FPREC - frac_bits - 1))) >> (FPREC - frac_bits);
   endfunction

endpackage

// File: rtl/bsexp_kring.sv
module bsexp_kring #(
   parameter int W      = 16,
   parameter int NSTAGE = 16
) (
   input  logic              clk,
   input  logic              rst,
   output logic [NSTAGE-1:0] kbits
);

   for (genvar g = 0; g < NSTAGE; g++) begin : g_ring
      localparam logic [W-1:0] KVAL = W'(bsexp_pkg::ln1p_pow2(g, W));
      logic [W-1:0] ring;
      always_ff @(posedge clk) begin
         if (rst) ring <= KVAL;
         else     ring <= {ring[0], ring[W-1:1]};
      end
      assign kbits[g] = ring[0];
   end

endmodule

// File: rtl/bsexp_stage.sv
module bsexp_stage #(
   parameter int W   = 16,
   parameter int PW  = 4,
   parameter int IDX = 0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [PW-1:0] phase,
   input  logic          last,
   input  logic          kbit,
   input  logic [W-1:0]  in_x,
   input  logic [W-1:0]  in_y,
   input  logic          in_v,
   output logic [W-1:0]  out_x,
   output logic [W-1:0]  out_y,
   output logic          out_v,
   output logic          dec_keep,
   output logic          dec_cout
);

   logic [W-2:0] xacc, yacc;
   logic         cx_q, by_q, nz_q;
   logic         first;
   logic         xa, xb, ya;
   logic         cx_in, by_in, nz_in;
   logic         xs, xc, ys, yb, ypos;

   assign first = (phase == '0);
   assign xa    = in_x[phase];
   assign ya    = in_y[phase];

   // addend x>>IDX seen LSB first: bit phase+IDX of the held word
   if (IDX == 0) begin : g_self
      assign xb = xa;
   end else begin : g_shift
      always_comb begin
         xb = 1'b0;
         for (int b = IDX; b < W; b++)
            if (phase == PW'(b - IDX)) xb = in_x[b];
      end
   end

   always_comb begin
      cx_in = first ? 1'b0 : cx_q;
      by_in = first ? 1'b0 : by_q;
      nz_in = first ? 1'b0 : nz_q;
      xs    = xa ^ xb ^ cx_in;
      xc    = (xa & xb) | (cx_in & (xa ^ xb));
      ys    = ya ^ kbit ^ by_in;
      yb    = (~ya & kbit) | (~(ya ^ kbit) & by_in);
      ypos  = ~yb & (nz_in | ys);
   end

   assign dec_keep = last & ypos;
   assign dec_cout = last & xc;

   always_ff @(posedge clk) begin
      if (rst) begin
         xacc  <= '0;
         yacc  <= '0;
         cx_q  <= 1'b0;
         by_q  <= 1'b0;
         nz_q  <= 1'b0;
         out_x <= '0;
         out_y <= '0;
         out_v <= 1'b0;
      end else begin
         xacc <= {xs, xacc[W-2:1]};
         yacc <= {ys, yacc[W-2:1]};
         cx_q <= xc;
         by_q <= yb;
         nz_q <= nz_in | ys;
         if (last) begin
            out_v <= in_v;
            if (ypos) begin
               out_x <= {xs, xacc};
               out_y <= {ys, yacc};
            end else begin
               out_x <= in_x;
               out_y <= in_y;
            end
         end
      end
   end

endmodule

// File: rtl/bsexp_pipe.sv
module bsexp_pipe #(
   parameter int W      = 16,
   parameter int XI     = 2,
   parameter int NSTAGE = W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              op_valid,
   input  logic              op_bit,
   output logic              slot_first,
   output logic              res_valid,
   output logic              res_bit,
   output logic [NSTAGE-1:0] kbits
);

   localparam int XF = W - XI;
   localparam int PW = $clog2(W);
   localparam logic [W-1:0] XONE = {{(W-1){1'b0}}, 1'b1} << XF;

   if (W < 3 || W > 24) begin : g_bad_w
      $error("bsexp_pipe: W must lie in 3..24");
   end
   if (XI < 2 || XI > W - 2) begin : g_bad_xi
      $error("bsexp_pipe: XI must lie in 2..W-2");
   end
   if (NSTAGE < 1 || NSTAGE > W) begin : g_bad_n
      $error("bsexp_pipe: NSTAGE must lie in 1..W");
   end

   logic [PW-1:0] phase;
   logic          last_bit;
   assign last_bit = (phase == PW'(W - 1));

   always_ff @(posedge clk) begin
      if (rst)           phase <= '0;
      else if (last_bit) phase <= '0;
      else               phase <= phase + PW'(1);
   end

   // serial argument capture
   logic [W-2:0] in_sr;
   logic         v_cap;
   logic [W-1:0] ent_y;
   logic         ent_v;

   always_ff @(posedge clk) begin
      if (rst) begin
         in_sr <= '0;
         v_cap <= 1'b0;
         ent_y <= '0;
         ent_v <= 1'b0;
      end else begin
         in_sr <= {op_bit, in_sr[W-2:1]};
         if (phase == '0) v_cap <= op_valid;
         if (last_bit) begin
            ent_y <= {op_bit, in_sr};
            ent_v <= v_cap;
         end
      end
   end

   logic [NSTAGE:0][W-1:0] sx;
   logic [NSTAGE:0][W-1:0] sy;
   logic [NSTAGE:0]        sv;
   logic [NSTAGE-1:0]      keep_vec;
   logic [NSTAGE-1:0]      cout_vec;

   assign sx[0] = XONE;
   assign sy[0] = ent_y;
   assign sv[0] = ent_v;

   bsexp_kring #(.W(W), .NSTAGE(NSTAGE)) u_kring (
      .clk   (clk),
      .rst   (rst),
      .kbits (kbits)
   );

   for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
      bsexp_stage #(.W(W), .PW(PW), .IDX(g)) u_st (
         .clk      (clk),
         .rst      (rst),
         .phase    (phase),
         .last     (last_bit),
         .kbit     (kbits[g]),
         .in_x     (sx[g]),
         .in_y     (sy[g]),
         .in_v     (sv[g]),
         .out_x    (sx[g+1]),
         .out_y    (sy[g+1]),
         .out_v    (sv[g+1]),
         .dec_keep (keep_vec[g]),
         .dec_cout (cout_vec[g])
      );
   end

   assign slot_first = (phase == '0);
   assign res_valid  = sv[NSTAGE];
   assign res_bit    = sv[NSTAGE] & sx[NSTAGE][phase];

endmodule

// File: rtl/bsexp_pipe_chk.sv
module bsexp_pipe_chk #(
   parameter int W      = 16,
   parameter int NSTAGE = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              slot_first,
   input logic              res_valid,
   input logic              res_bit,
   input logic [NSTAGE:0]   sv,
   input logic [NSTAGE-1:0] keep_vec,
   input logic [NSTAGE-1:0] cout_vec
);

   localparam int PW = $clog2(W);
   logic [PW-1:0] ph;

   always_ff @(posedge clk) begin
      if (rst)                    ph <= '0;
      else if (ph == PW'(W - 1))  ph <= '0;
      else                        ph <= ph + PW'(1);
   end

   assert_slot_phase_R7: assert property (@(posedge clk) disable iff (rst)
      slot_first == (ph == '0));

   assert_bubble_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      !res_valid |-> !res_bit);

   assert_valid_held_R2: assert property (@(posedge clk) disable iff (rst)
      (res_valid && !slot_first) |-> $past(res_valid));

   assert_valid_advance_R2: assert property (@(posedge clk) disable iff (rst)
      (ph == PW'(W - 1)) |=> (sv[NSTAGE:1] == $past(sv[NSTAGE-1:0])));

   assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
      !(|(keep_vec & cout_vec)));

endmodule

bind bsexp_pipe bsexp_pipe_chk #(.W(W), .NSTAGE(NSTAGE)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .slot_first (slot_first),
   .res_valid  (res_valid),
   .res_bit    (res_bit),
   .sv         (sv),
   .keep_vec   (keep_vec),
   .cout_vec   (cout_vec)
);

// File: tb/bsexp_pipe_tb.sv
`timescale 1ns/1ps
module bsexp_pipe_tb;

   localparam int W     = 16;
   localparam int XI    = 2;
   localparam int N     = W;
   localparam int XF    = W - XI;
   localparam int NIN   = 48;
   localparam int NSLOT = NIN + N + 2;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         op_valid = 1'b0;
   logic         op_bit = 1'b0;
   logic         slot_first, res_valid, res_bit;
   logic [N-1:0] kbits;

   bsexp_pipe #(.W(W), .XI(XI), .NSTAGE(N)) u_dut (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op_bit(op_bit),
      .slot_first(slot_first), .res_valid(res_valid), .res_bit(res_bit), .kbits(kbits)
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   int kc [N];
   int args [NIN];
   bit vin [NIN];
   int mres [NIN];
   logic [W-1:0] got_w;

   task automatic check(input bit ok, input string tag, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic int model_exp(input int a);
      longint x, y, xt;
      x = longint'(1) << XF;
      y = a;
      for (int i = 0; i < N; i++) begin
         xt = (x + (x >> i)) & ((longint'(1) << W) - 1);
         if (y > kc[i]) begin
            x = xt;
            y = y - kc[i];
         end
      end
      return int'(x);
   endfunction

   initial begin
      int unsigned seed;
      int s, j, so;
      bit ev, eb;
      logic [N-1:0] ek;
      real e, g, d;
      for (int i = 0; i < N; i++)
         kc[i] = int'($floor($ln(1.0 + 2.0 ** (-i)) * 2.0 ** W + 0.5));
      seed = 32'h1234_5678;
      for (int i = 0; i < NIN; i++) begin
         seed = seed * 32'd1103515245 + 32'd12345;
         args[i] = int'((seed >> 8) & ((1 << W) - 1));
         vin[i]  = (i % 7) != 3;
      end
      args[0] = 0;           vin[0] = 1'b1;
      args[1] = kc[0];       vin[1] = 1'b1;
      args[2] = kc[0] + 1;   vin[2] = 1'b1;
      args[4] = (1 << W) - 1; vin[4] = 1'b1;
      args[5] = 1;           vin[5] = 1'b1;
      args[6] = 1 << (W-1); vin[6] = 1'b1;
      args[7] = kc[0] - 1;   vin[7] = 1'b1;
      for (int i = 0; i < NIN; i++) mres[i] = model_exp(args[i]);

      // R10: state while reset is held
      repeat (3) @(negedge clk);
      check(slot_first === 1'b1, "R10 slot_first in reset", slot_first, 1);
      check(res_valid === 1'b0 && res_bit === 1'b0, "R10 outputs in reset",
            {res_valid, res_bit}, 0);
      rst = 1'b0;

      for (int k = 0; k < NSLOT * W; k++) begin
         s  = k / W;
         j  = k % W;
         so = s - (N + 1);
         ev = (so >= 0 && so < NIN) ? vin[so] : 1'b0;
         eb = ev ? ((mres[so] >> j) & 1) == 1 : 1'b0;
         check(res_valid === ev && res_bit === eb, ev ? "R2 R3 R8 result bit" : "R8 R9 idle slot",
               {res_valid, res_bit}, {ev, eb});
         check(slot_first === (j == 0), "R7 slot_first", slot_first, (j == 0));
         for (int i = 0; i < N; i++) ek[i] = ((kc[i] >> j) & 1) == 1;
         check(kbits === ek, "R6 constant broadcast", kbits, ek);
         if (ev) begin
            got_w[j] = res_bit;
            if (j == W - 1) begin
               e = $exp(real'(args[so]) / 2.0 ** W);
               g = real'(got_w) / 2.0 ** XF;
               d = (g - e) * 2.0 ** XF;
               if (d < 0.0) d = -d;
               check(d <= 32.0, "R1 accuracy vs exp", got_w, int'(e * 2.0 ** XF));
               if (args[so] == 0)
                  check(got_w == (1 << XF), "R5 zero argument", got_w, 1 << XF);
               if (args[so] == kc[0])
                  check(got_w < (1 << (W-1)), "R4 zero residual discarded", got_w, (1 << (W-1)) - 1);
               if (args[so] == kc[0] + 1)
                  check(got_w == (1 << (W-1)), "R4 one LSB above c0", got_w, 1 << (W-1));
               if (args[so] == (1 << W) - 1)
                  check(got_w > (1 << (W-1)), "R11 no wrap at max argument", got_w, mres[so]);
            end
         end
         if (s < NIN) begin
            op_bit   = ((args[s] >> j) & 1) == 1;
            op_valid = (j == 0) ? vin[s] : !vin[s];
         end else begin
            op_bit   = 1'b0;
            op_valid = 1'b0;
         end
         @(negedge clk);
      end
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule